// File: doc/BRIEF.md
# Region access permission checker

This block decides whether one bus access may proceed, using a small bank of region descriptors held in registers elsewhere. Each descriptor gives an address window, a rights word covering eight bus masters, a valid flag, and a process identifier with an ignore mask. For each access the block reports three things: which regions match, whether the access is granted, and the class of any violation.

Masters 0 to 3 carry full read/write/execute rights, with separate user and supervisor settings and an optional process identifier check. Masters 4 to 7 carry only read and write flags. When an access falls in several regions, it passes if any one of them allows it. A global enable turns all checking off.

The inputs are sampled on a clock edge and the verdict appears on registered outputs one cycle later, so the result path is a single pipeline stage.

Top module: `mpu_region_checker`

## Requirements
- R1: A region's window runs from its start address with the low 5 bits cleared to its end address with the low 5 bits set, both bounds inclusive. An access at an address outside the window does not hit that region.
- R2: For masters 0 to 3, master n owns bits [6n+5:6n] of the rights word. Bits [2:0] of the field are the user rights mask: bit 2 allows read, bit 1 allows write, bit 0 allows execute.
- R3: Field bits [4:3] give the supervisor code. Code 0 allows read, write and execute. Code 1 allows read and execute. Code 2 allows read and write. Code 3 applies the user mask. The code is used only when acc_super is 1.
- R4: For masters 4 to 7, master n uses bits [24+2(n-4)+1 : 24+2(n-4)]. The lower bit allows write and the upper bit allows read. An execute access by these masters is checked against the read bit. acc_kind encodes 0 as read, 1 as write and 2 as execute; code 3 is never allowed.
- R5: When bit 5 of the field of master n (0 to 3) is set, the region hits only if acc_pid and the region's identifier agree in every bit that is clear in the region's mask. When that bit is clear, the identifier plays no part.
- R6: A region whose valid flag is clear never hits, whatever its address and rights.
- R7: With checking enabled, an access that hits no region is denied, with res_err=1 and res_err_class=0.
- R8: With checking enabled, an access that hits one or more regions but is allowed by none of them is denied with res_err=1. res_err_class is 1 when exactly one region hits and 2 when two or more hit.
- R9: With checking enabled, an access is granted with res_err=0 and res_err_class=0 if at least one hitting region allows it, even when other hitting regions do not.
- R10: With chk_en=0, every access is granted with res_err=0 and res_err_class=0. res_hit still reports the matching regions.
- R11: The outputs register the verdict for the inputs present at a rising clock edge, and res_valid follows acc_valid by one cycle. After reset, res_valid, res_grant and res_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_en | input | 1 | Global checking enable |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Access byte address |
| acc_master | input | 3 | Bus master number 0 to 7 |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute |
| acc_super | input | 1 | 1 for supervisor mode, 0 for user mode |
| acc_pid | input | PID_W | Process identifier of the access |
| rgn_start | input | NUM_RGN*ADDR_W | Start addresses, region g at slice g |
| rgn_end | input | NUM_RGN*ADDR_W | End addresses |
| rgn_rights | input | NUM_RGN*32 | Rights words |
| rgn_valid | input | NUM_RGN | Per-region valid flags |
| rgn_pid | input | NUM_RGN*PID_W | Region process identifiers |
| rgn_pidmask | input | NUM_RGN*PID_W | Identifier bits to ignore |
| res_valid | output | 1 | Verdict valid |
| res_grant | output | 1 | Access granted |
| res_err | output | 1 | Access violation |
| res_err_class | output | 2 | 0 no hit, 1 single region, 2 overlapping regions |
| res_hit | output | NUM_RGN | Regions matched by the access |

## Verification
On every cycle, the assertions check four relations at the registered outputs against the per-region hit and allow wires: an enabled access that hits nothing is denied with class 0; an access that some hitting region allows is granted; a disabled checker passes everything; and an error never comes with a grant or with class 2 on fewer than two hits. The decoding of rights has to be shown by the bench's scenarios. That covers the field positions per master, the four supervisor codes, the read and write flags of the higher masters, the masked identifier compare and the 32-byte window edges, since a property cannot tell a wrong bit position from a right one without restating the decode.

// File: rtl/mpu_chk_pkg.sv
`timescale 1ns/1ps
package mpu_chk_pkg;

  localparam int MASTER_W   = 3;
  localparam int RIGHTS_W   = 32;
  localparam int PRIV_FLD_W = 6;
  localparam int RW_BASE    = 24;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_EXEC  = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    ERR_NO_HIT  = 2'd0,
    ERR_SINGLE  = 2'd1,
    ERR_OVERLAP = 2'd2
  } err_class_e;

  // Effective rwx mask in supervisor mode; code 3 defers to the user mask.
  function automatic logic [2:0] super_mask(input logic [1:0] code,
                                            input logic [2:0] user);
    case (code)
      2'd0:    return 3'b111;
      2'd1:    return 3'b101;
      2'd2:    return 3'b110;
      default: return user;
    endcase
  endfunction

  // Select the rwx bit that the access kind needs.
  function automatic logic rwx_permits(input logic [2:0] rwx,
                                       input logic [1:0] kind);
    case (kind)
      KIND_READ:  return rwx[2];
      KIND_WRITE: return rwx[1];
      KIND_EXEC:  return rwx[0];
      default:    return 1'b0;
    endcase
  endfunction

  // Read/write-only masters: fetches are judged by the read flag.
  function automatic logic rw_permits(input logic [1:0] rw,
                                      input logic [1:0] kind);
    case (kind)
      KIND_READ:  return rw[1];
      KIND_WRITE: return rw[0];
      KIND_EXEC:  return rw[1];
      default:    return 1'b0;
    endcase
  endfunction

  // Masked identifier compare: set mask bits are don't-care.
  function automatic logic pid_agrees(input logic [7:0] a,
                                      input logic [7:0] b,
                                      input logic [7:0] ignore);
    return ((a ^ b) & ~ignore) == 8'd0;
  endfunction

  // True when two or more bits of v are set.
  function automatic logic several(input logic [15:0] v);
    return (v & (v - 16'd1)) != 16'd0;
  endfunction

endpackage

// File: rtl/mpu_region_match.sv
`timescale 1ns/1ps
module mpu_region_match
  import mpu_chk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PID_W     = 8,
  parameter int GRAN_BITS = 5
) (
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [MASTER_W-1:0] acc_master,
  input  logic [1:0]          acc_kind,
  input  logic                acc_super,
  input  logic [PID_W-1:0]    acc_pid,
  input  logic [ADDR_W-1:0]   win_start,
  input  logic [ADDR_W-1:0]   win_end,
  input  logic [RIGHTS_W-1:0] rights,
  input  logic                win_valid,
  input  logic [PID_W-1:0]    win_pid,
  input  logic [PID_W-1:0]    win_pidmask,
  output logic                hit,
  output logic                allow
);

  localparam logic [ADDR_W-1:0] GMASK =
    {{(ADDR_W-GRAN_BITS){1'b0}}, {GRAN_BITS{1'b1}}};

  logic [ADDR_W-1:0]     lo_bound, hi_bound;
  logic                  in_window;
  logic                  is_priv;
  int                    fld_idx;
  logic [PRIV_FLD_W-1:0] priv_fld;
  logic [1:0]            rw_fld;
  logic                  pid_on, pid_ok;
  logic [2:0]            eff_rwx;
  logic [7:0]            pid_a, pid_b, pid_m;

  assign lo_bound  = win_start & ~GMASK;
  assign hi_bound  = win_end | GMASK;
  assign in_window = (acc_addr >= lo_bound) && (acc_addr <= hi_bound);

  assign is_priv  = ~acc_master[MASTER_W-1];
  assign fld_idx  = int'(acc_master[1:0]);
  assign priv_fld = rights[PRIV_FLD_W*fld_idx +: PRIV_FLD_W];
  assign rw_fld   = rights[RW_BASE + 2*fld_idx +: 2];

  assign pid_a  = 8'(acc_pid);
  assign pid_b  = 8'(win_pid);
  assign pid_m  = 8'(win_pidmask);
  assign pid_on = is_priv & priv_fld[5];
  assign pid_ok = ~pid_on | pid_agrees(pid_a, pid_b, pid_m);

  assign hit = win_valid & in_window & pid_ok;

  assign eff_rwx = acc_super ? super_mask(priv_fld[4:3], priv_fld[2:0])
                             : priv_fld[2:0];

  assign allow = is_priv ? rwx_permits(eff_rwx, acc_kind)
                         : rw_permits(rw_fld, acc_kind);

endmodule

// File: rtl/mpu_verdict.sv
`timescale 1ns/1ps
module mpu_verdict
  import mpu_chk_pkg::*;
#(
  parameter int NUM_RGN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chk_en,
  input  logic [NUM_RGN-1:0] hit,
  input  logic [NUM_RGN-1:0] allow,
  output logic               grant,
  output logic               err,
  output logic [1:0]         err_class
);

  logic [NUM_RGN-1:0] passing;
  err_class_e         cls;

  assign passing = hit & allow;

  always_comb begin
    grant = 1'b1;
    err   = 1'b0;
    cls   = ERR_NO_HIT;
    if (chk_en && passing == '0) begin
      grant = 1'b0;
      err   = 1'b1;
      if (hit == '0)
        cls = ERR_NO_HIT;
      else if (several(16'(hit)))
        cls = ERR_OVERLAP;
      else
        cls = ERR_SINGLE;
    end
  end

  assign err_class = cls;

  // R10
  err_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> chk_en);

endmodule

// File: rtl/mpu_region_checker.sv
`timescale 1ns/1ps
module mpu_region_checker
  import mpu_chk_pkg::*;
#(
  parameter int NUM_RGN   = 4,
  parameter int ADDR_W    = 32,
  parameter int PID_W     = 8,
  parameter int GRAN_BITS = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        chk_en,
  input  logic                        acc_valid,
  input  logic [ADDR_W-1:0]           acc_addr,
  input  logic [2:0]                  acc_master,
  input  logic [1:0]                  acc_kind,
  input  logic                        acc_super,
  input  logic [PID_W-1:0]            acc_pid,
  input  logic [NUM_RGN*ADDR_W-1:0]   rgn_start,
  input  logic [NUM_RGN*ADDR_W-1:0]   rgn_end,
  input  logic [NUM_RGN*32-1:0]       rgn_rights,
  input  logic [NUM_RGN-1:0]          rgn_valid,
  input  logic [NUM_RGN*PID_W-1:0]    rgn_pid,
  input  logic [NUM_RGN*PID_W-1:0]    rgn_pidmask,
  output logic                        res_valid,
  output logic                        res_grant,
  output logic                        res_err,
  output logic [1:0]                  res_err_class,
  output logic [NUM_RGN-1:0]          res_hit
);

  logic [NUM_RGN-1:0] hit_w, allow_w;
  logic               grant_w, err_w;
  logic [1:0]         class_w;

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    mpu_region_match #(
      .ADDR_W(ADDR_W), .PID_W(PID_W), .GRAN_BITS(GRAN_BITS)
    ) u_match (
      .acc_addr   (acc_addr),
      .acc_master (acc_master),
      .acc_kind   (acc_kind),
      .acc_super  (acc_super),
      .acc_pid    (acc_pid),
      .win_start  (rgn_start[g*ADDR_W +: ADDR_W]),
      .win_end    (rgn_end[g*ADDR_W +: ADDR_W]),
      .rights     (rgn_rights[g*RIGHTS_W +: RIGHTS_W]),
      .win_valid  (rgn_valid[g]),
      .win_pid    (rgn_pid[g*PID_W +: PID_W]),
      .win_pidmask(rgn_pidmask[g*PID_W +: PID_W]),
      .hit        (hit_w[g]),
      .allow      (allow_w[g])
    );
  end

  mpu_verdict #(.NUM_RGN(NUM_RGN)) u_verdict (
    .clk      (clk),
    .rst_n    (rst_n),
    .chk_en   (chk_en),
    .hit      (hit_w),
    .allow    (allow_w),
    .grant    (grant_w),
    .err      (err_w),
    .err_class(class_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_grant     <= 1'b0;
      res_err       <= 1'b0;
      res_err_class <= 2'd0;
      res_hit       <= '0;
    end else begin
      res_valid     <= acc_valid;
      res_grant     <= grant_w;
      res_err       <= err_w;
      res_err_class <= class_w;
      res_hit       <= hit_w;
    end
  end

  // R7
  no_hit_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && chk_en && hit_w == '0
      |=> res_valid && !res_grant && res_err && res_err_class == 2'd0);

  // R9
  any_allow_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && chk_en && (hit_w & allow_w) != '0
      |=> res_grant && !res_err && res_err_class == 2'd0);

  // R10
  bypass_grants_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !chk_en |=> res_grant && !res_err);

  // R8
  err_excludes_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> !res_grant);

  // R8
  overlap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_err_class == 2'd2 |-> $countones(res_hit) > 1);

endmodule

// File: tb/mpu_region_checker_tb.sv
`timescale 1ns/1ps
module mpu_region_checker_tb;

  localparam int NR = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n, chk_en, acc_valid, acc_super;
  logic [31:0]       acc_addr;
  logic [2:0]        acc_master;
  logic [1:0]        acc_kind;
  logic [7:0]        acc_pid;
  logic [NR*32-1:0]  f_start, f_end, f_rights;
  logic [NR*8-1:0]   f_pid, f_mask;
  logic [NR-1:0]     vl;
  logic              res_valid, res_grant, res_err;
  logic [1:0]        res_err_class;
  logic [NR-1:0]     res_hit;

  logic [31:0] st [NR];
  logic [31:0] en [NR];
  logic [31:0] rt [NR];
  logic [7:0]  pd [NR];
  logic [7:0]  pm [NR];

  int n_checks = 0;
  int n_fail   = 0;

  for (genvar g = 0; g < NR; g++) begin : g_pack
    assign f_start[g*32 +: 32] = st[g];
    assign f_end[g*32 +: 32]   = en[g];
    assign f_rights[g*32 +: 32] = rt[g];
    assign f_pid[g*8 +: 8]     = pd[g];
    assign f_mask[g*8 +: 8]    = pm[g];
  end

  mpu_region_checker #(.NUM_RGN(NR)) u_dut (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_master(acc_master), .acc_kind(acc_kind),
    .acc_super(acc_super), .acc_pid(acc_pid),
    .rgn_start(f_start), .rgn_end(f_end), .rgn_rights(f_rights),
    .rgn_valid(vl), .rgn_pid(f_pid), .rgn_pidmask(f_mask),
    .res_valid(res_valid), .res_grant(res_grant), .res_err(res_err),
    .res_err_class(res_err_class), .res_hit(res_hit)
  );

  // Rights field of a read/write/execute master (0..3).
  function automatic logic [31:0] prf(int n, logic [2:0] u, logic [1:0] s, logic pe);
    return {26'd0, pe, s, u} << (6 * n);
  endfunction

  // Rights field of a read/write master (4..7): upper bit read, lower write.
  function automatic logic [31:0] rwf(int n, logic rd, logic wr);
    return {30'd0, rd, wr} << (24 + 2 * (n - 4));
  endfunction

  // Drive one access for one clock edge; returns at the following negedge.
  task automatic access(input logic [31:0] a, input logic [2:0] m,
                        input logic [1:0] k, input logic s, input logic [7:0] p);
    @(negedge clk);
    acc_addr = a; acc_master = m; acc_kind = k; acc_super = s; acc_pid = p;
    acc_valid = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic expect_res(input string tag, input logic g,
                            input logic [1:0] c, input logic [NR-1:0] h);
    n_checks++;
    if (res_valid !== 1'b1 || res_grant !== g || res_err !== !g ||
        res_err_class !== c || res_hit !== h) begin
      n_fail++;
      $display("FAIL %s: got valid=%b grant=%b err=%b class=%0d hit=%b, expected valid=1 grant=%b err=%b class=%0d hit=%b",
               tag, res_valid, res_grant, res_err, res_err_class, res_hit,
               g, !g, c, h);
    end
  endtask

  task automatic base_setup();
    for (int i = 0; i < NR; i++) begin
      st[i] = '0; en[i] = '0; rt[i] = '0; pd[i] = '0; pm[i] = '0;
    end
    vl = '0;
    st[0] = 32'h0000_1010;
    en[0] = 32'h0000_1FE0;
    rt[0] = prf(0, 3'b100, 2'd3, 1'b0) | prf(1, 3'b111, 2'd3, 1'b1) |
            rwf(5, 1'b1, 1'b0);
    pd[0] = 8'h5A;
    pm[0] = 8'h0F;
    vl[0] = 1'b1;
    chk_en = 1'b1;
  endtask

  task automatic t_reset();
    // R11 reset state
    n_checks++;
    if (res_valid !== 1'b0 || res_grant !== 1'b0 || res_err !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 reset: got valid=%b grant=%b err=%b, expected 0 0 0",
               res_valid, res_grant, res_err);
    end
  endtask

  task automatic t_range();
    base_setup();
    access(32'h0000_1000, 3'd0, 2'd0, 1'b0, 8'h00);
    expect_res("R1 start aligned down", 1'b1, 2'd0, 4'b0001);
    access(32'h0000_0FFF, 3'd0, 2'd0, 1'b0, 8'h00);
    expect_res("R1/R7 below start", 1'b0, 2'd0, 4'b0000);
    access(32'h0000_1FFF, 3'd0, 2'd0, 1'b0, 8'h00);
    expect_res("R1 end aligned up", 1'b1, 2'd0, 4'b0001);
    access(32'h0000_2000, 3'd0, 2'd0, 1'b0, 8'h00);
    expect_res("R1/R7 above end", 1'b0, 2'd0, 4'b0000);
  endtask

  task automatic t_user();
    base_setup();
    access(32'h0000_1100, 3'd0, 2'd1, 1'b0, 8'h00);
    expect_res("R2 user write denied", 1'b0, 2'd1, 4'b0001);
    access(32'h0000_1100, 3'd0, 2'd2, 1'b0, 8'h00);
    expect_res("R2 user exec denied", 1'b0, 2'd1, 4'b0001);
    access(32'h0000_1100, 3'd1, 2'd2, 1'b0, 8'h5A);
    expect_res("R2 master1 field full rights", 1'b1, 2'd0, 4'b0001);
  endtask

  task automatic t_super();
    base_setup();
    rt[0] = prf(0, 3'b000, 2'd1, 1'b0);
    access(32'h0000_1100, 3'd0, 2'd0, 1'b1, 8'h00);
    expect_res("R3 code1 read", 1'b1, 2'd0, 4'b0001);
    access(32'h0000_1100, 3'd0, 2'd1, 1'b1, 8'h00);
    expect_res("R3 code1 write denied", 1'b0, 2'd1, 4'b0001);
    access(32'h0000_1100, 3'd0, 2'd2, 1'b1, 8'h00);
    expect_res("R3 code1 exec", 1'b1, 2'd0, 4'b0001);
    access(32'h0000_1100, 3'd0, 2'd0, 1'b0, 8'h00);
    expect_res("R3 user mode ignores code", 1'b0, 2'd1, 4'b0001);
    rt[0] = prf(0, 3'b000, 2'd2, 1'b0);
    access(32'h0000_1100, 3'd0, 2'd2, 1'b1, 8'h00);
    expect_res("R3 code2 exec denied", 1'b0, 2'd1, 4'b0001);
    access(32'h0000_1100, 3'd0, 2'd1, 1'b1, 8'h00);
    expect_res("R3 code2 write", 1'b1, 2'd0, 4'b0001);
    rt[0] = prf(0, 3'b000, 2'd0, 1'b0);
    access(32'h0000_1100, 3'd0, 2'd2, 1'b1, 8'h00);
    expect_res("R3 code0 exec", 1'b1, 2'd0, 4'b0001);
    rt[0] = prf(0, 3'b100, 2'd3, 1'b0);
    access(32'h0000_1100, 3'd0, 2'd0, 1'b1, 8'h00);
    expect_res("R3 code3 read via user", 1'b1, 2'd0, 4'b0001);
    access(32'h0000_1100, 3'd0, 2'd1, 1'b1, 8'h00);
    expect_res("R3 code3 write via user", 1'b0, 2'd1, 4'b0001);
  endtask

  task automatic t_rw();
    base_setup();
    access(32'h0000_1100, 3'd5, 2'd0, 1'b0, 8'h00);
    expect_res("R4 master5 read", 1'b1, 2'd0, 4'b0001);
    access(32'h0000_1100, 3'd5, 2'd1, 1'b1, 8'h00);
    expect_res("R4 master5 write denied", 1'b0, 2'd1, 4'b0001);
    access(32'h0000_1100, 3'd5, 2'd2, 1'b0, 8'h00);
    expect_res("R4 master5 exec as read", 1'b1, 2'd0, 4'b0001);
    access(32'h0000_1100, 3'd6, 2'd0, 1'b0, 8'h00);
    expect_res("R4 master6 no rights", 1'b0, 2'd1, 4'b0001);
    rt[0] = rwf(7, 1'b0, 1'b1);
    access(32'h0000_1100, 3'd7, 2'd1, 1'b0, 8'h00);
    expect_res("R4 master7 write", 1'b1, 2'd0, 4'b0001);
    access(32'h0000_1100, 3'd7, 2'd3, 1'b0, 8'h00);
    expect_res("R4 reserved kind denied", 1'b0, 2'd1, 4'b0001);
  endtask

  task automatic t_pid();
    base_setup();
    access(32'h0000_1100, 3'd1, 2'd0, 1'b0, 8'h53);
    expect_res("R5 pid match under mask", 1'b1, 2'd0, 4'b0001);
    access(32'h0000_1100, 3'd1, 2'd0, 1'b0, 8'h6A);
    expect_res("R5 pid mismatch no hit", 1'b0, 2'd0, 4'b0000);
    rt[0] = prf(1, 3'b111, 2'd3, 1'b0);
    access(32'h0000_1100, 3'd1, 2'd0, 1'b0, 8'h6A);
    expect_res("R5 pid check off", 1'b1, 2'd0, 4'b0001);
  endtask

  task automatic t_overlap();
    base_setup();
    st[1] = 32'h0000_1800; en[1] = 32'h0000_27FF;
    rt[1] = prf(0, 3'b010, 2'd3, 1'b0);
    vl[1] = 1'b1;
    access(32'h0000_1900, 3'd0, 2'd1, 1'b0, 8'h00);
    expect_res("R9 one of two allows", 1'b1, 2'd0, 4'b0011);
    access(32'h0000_1900, 3'd0, 2'd2, 1'b0, 8'h00);
    expect_res("R8 overlap denied class2", 1'b0, 2'd2, 4'b0011);
    access(32'h0000_2100, 3'd0, 2'd2, 1'b0, 8'h00);
    expect_res("R8 single denied class1", 1'b0, 2'd1, 4'b0010);
    // R6 disabled regions stop hitting
    vl[1] = 1'b0;
    access(32'h0000_1900, 3'd0, 2'd1, 1'b0, 8'h00);
    expect_res("R6 region1 disabled", 1'b0, 2'd1, 4'b0001);
    vl[0] = 1'b0;
    access(32'h0000_1100, 3'd0, 2'd0, 1'b0, 8'h00);
    expect_res("R6 region0 disabled", 1'b0, 2'd0, 4'b0000);
  endtask

  task automatic t_global();
    base_setup();
    chk_en = 1'b0;
    access(32'h0000_0000, 3'd0, 2'd1, 1'b0, 8'h00);
    expect_res("R10 bypass no hit", 1'b1, 2'd0, 4'b0000);
    access(32'h0000_1100, 3'd0, 2'd1, 1'b0, 8'h00);
    expect_res("R10 bypass denied rights", 1'b1, 2'd0, 4'b0001);
    chk_en = 1'b1;
    @(negedge clk);
    // R11 res_valid drops one cycle after acc_valid
    n_checks++;
    if (res_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R11 idle: got valid=%b, expected 0", res_valid);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; acc_addr = '0; acc_master = '0;
    acc_kind = '0; acc_super = 1'b0; acc_pid = '0;
    base_setup();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_range();
    t_user();
    t_super();
    t_rw();
    t_pid();
    t_overlap();
    t_global();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule